// File: doc/BRIEF.md
# Fixed-Priority Eight-Line Interrupt Controller

This block gathers eight interrupt request lines, latches a rising edge on each into a pending bit, and filters the pending bits through a software-writable mask in which a 1 blocks a line and a 0 lets it through. When nothing is in service and at least one pending, unblocked line exists, it raises a request towards the processor. When the processor acknowledges, the controller moves the winning line (the lowest-numbered candidate) from pending to in-service and returns a vector number equal to the vector base plus the line number.

While a line is in service, no further request reaches the processor from any line. Software releases the controller by writing the end-of-interrupt code 0x20 to the command port. The register side is byte wide with two ports chosen by one address bit: address 0 is the command port and address 1 is the mask port.

The control state machine has three states. `ST_IDLE` waits for a candidate, with the request low. `ST_ASSERT` drives the request high. `ST_INSERVICE` holds one line in service. The transitions are as follows. *arm* goes from `ST_IDLE` to `ST_ASSERT` when a pending, unblocked line exists. *withdraw* goes from `ST_ASSERT` back to `ST_IDLE` when no candidate remains. *accept* goes from `ST_ASSERT` to `ST_INSERVICE` on an acknowledge with a candidate present. *release* goes from `ST_INSERVICE` to `ST_IDLE` on an end-of-interrupt write.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, the in-service byte reads 0x00, `int_req` is low and no line is pending.
- R2: A write to address 1 sets the mask, and a read at address 1 returns the last value written.
- R3: A mask bit at 1 keeps its line from raising `int_req`. The line's pending bit is kept, and the line is delivered once its mask bit returns to 0.
- R4: A rising edge on `irq_in[n]` sets pending bit n. A line held high after it has been serviced does not request again.
- R5: Among the candidates, line 0 has the highest priority and line 7 the lowest.
- R6: An accepted acknowledge drives `vec_valid` high for one cycle in the next cycle, with `vec_num` = 8 + n.
- R7: After an acceptance, the in-service byte (read at address 0) has bit n set. `int_req` then stays low, whatever other lines request, until an end-of-interrupt is written.
- R8: Writing 0x20 to address 0 clears the highest-priority in-service bit. A line left pending is then requested again.
- R9: A command write at address 0 with any value other than 0x20 leaves the in-service byte unchanged.
- R10: An acknowledge that arrives when no pending, unblocked line exists produces no `vec_valid` and puts nothing in service.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Request lines; a rising edge requests |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the command port, 1 selects the mask port |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data: in-service byte at 0, mask at 1 |
| int_req | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | Single-cycle acknowledge from the processor |
| vec_valid | output | 1 | Vector number is valid |
| vec_num | output | 8 | Vector number, base plus line |

## Verification
The bench builds the block with its default values: eight lines and a vector base of 8. This configuration is small enough to sweep every line on its own and every ordered pair of lines for priority. The bench also blocks each line in turn while all eight lines fire together. It drives the acknowledge straight after a mask change that removes the only candidate, which exercises the corner where an acknowledge arrives with nothing to accept.

// File: rtl/pic_pkg.sv
package pic_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_ASSERT    = 2'd1,
        ST_INSERVICE = 2'd2
    } pic_state_t;

    localparam int          DATA_W   = 8;
    localparam logic [7:0]  EOI_CODE = 8'h20;
endpackage

// File: rtl/pic_edge_pend.sv
module pic_edge_pend #(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] lines,
    input  logic [N_LINES-1:0] clr,
    output logic [N_LINES-1:0] pend
);
    logic [N_LINES-1:0] lines_q;
    logic [N_LINES-1:0] rise;

    assign rise = lines & ~lines_q;

    // A fresh edge wins over a clear in the same cycle.
    genvar g;
    generate
        for (g = 0; g < N_LINES; g++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    lines_q[g] <= 1'b0;
                    pend[g]    <= 1'b0;
                end else begin
                    lines_q[g] <= lines[g];
                    if (rise[g])
                        pend[g] <= 1'b1;
                    else if (clr[g])
                        pend[g] <= 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/pic_prio.sv
module pic_prio #(
    parameter int N_LINES = 8,
    localparam int IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic [N_LINES-1:0] cand,
    output logic [N_LINES-1:0] grant,
    output logic [IDX_W-1:0]   idx,
    output logic               any
);
    // Line 0 beats every higher-numbered line.
    genvar g;
    generate
        for (g = 0; g < N_LINES; g++) begin : g_gnt
            if (g == 0) begin : g_top
                assign grant[g] = cand[g];
            end else begin : g_rest
                assign grant[g] = cand[g] & ~(|cand[g-1:0]);
            end
        end
    endgenerate

    assign any = |cand;

    always_comb begin
        idx = '0;
        for (int i = 0; i < N_LINES; i++) begin
            if (grant[i])
                idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/pic_fsm.sv
module pic_fsm
    import pic_pkg::*;
#(
    parameter int N_LINES  = 8,
    parameter int VEC_BASE = 8,
    localparam int IDX_W   = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               any_cand,
    input  logic [N_LINES-1:0] grant,
    input  logic [IDX_W-1:0]   grant_idx,
    input  logic               ack,
    input  logic               eoi,
    output logic [N_LINES-1:0] isr,
    output logic [N_LINES-1:0] take_mask,
    output logic               int_req,
    output logic               vec_valid,
    output logic [DATA_W-1:0]  vec_num
);
    pic_state_t state, state_n;
    logic       take;

    assign take      = (state == ST_ASSERT) && ack && any_cand;
    assign take_mask = take ? grant : '0;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_n;
    end

    // Transitions: arm, withdraw, accept, release
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (any_cand)
                    state_n = ST_ASSERT;
            end
            ST_ASSERT: begin
                if (take)
                    state_n = ST_INSERVICE;
                else if (!any_cand)
                    state_n = ST_IDLE;
            end
            ST_INSERVICE: begin
                if (eoi)
                    state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // Outputs and in-service register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isr       <= '0;
            vec_valid <= 1'b0;
            vec_num   <= '0;
        end else begin
            vec_valid <= take;
            if (take) begin
                isr     <= isr | grant;
                vec_num <= DATA_W'(VEC_BASE) + DATA_W'(grant_idx);
            end else if (eoi) begin
                isr     <= isr & (isr - 1'b1);
            end
        end
    end

    assign int_req = (state == ST_ASSERT);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int N_LINES  = 8,
    parameter int VEC_BASE = 8,
    localparam int IDX_W   = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_LINES-1:0] irq_in,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              int_req,
    input  logic              int_ack,
    output logic              vec_valid,
    output logic [DATA_W-1:0] vec_num
);
    logic [N_LINES-1:0] mask_q;
    logic [N_LINES-1:0] pend;
    logic [N_LINES-1:0] cand;
    logic [N_LINES-1:0] grant;
    logic [N_LINES-1:0] take_mask;
    logic [N_LINES-1:0] isr;
    logic [IDX_W-1:0]   grant_idx;
    logic               any_cand;
    logic               eoi;

    assign eoi = reg_wr && !reg_addr && (reg_wdata == EOI_CODE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask_q <= '1;
        else if (reg_wr && reg_addr)
            mask_q <= reg_wdata[N_LINES-1:0];
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr)
            reg_rdata[N_LINES-1:0] = mask_q;
        else
            reg_rdata[N_LINES-1:0] = isr;
    end

    // Any in-service line blocks all candidates.
    assign cand = (|isr) ? '0 : (pend & ~mask_q);

    pic_edge_pend #(.N_LINES(N_LINES)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .lines (irq_in),
        .clr   (take_mask),
        .pend  (pend)
    );

    pic_prio #(.N_LINES(N_LINES)) u_prio (
        .cand  (cand),
        .grant (grant),
        .idx   (grant_idx),
        .any   (any_cand)
    );

    pic_fsm #(.N_LINES(N_LINES), .VEC_BASE(VEC_BASE)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_cand  (any_cand),
        .grant     (grant),
        .grant_idx (grant_idx),
        .ack       (int_ack),
        .eoi       (eoi),
        .isr       (isr),
        .take_mask (take_mask),
        .int_req   (int_req),
        .vec_valid (vec_valid),
        .vec_num   (vec_num)
    );
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
    parameter int N_LINES  = 8,
    parameter int VEC_BASE = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic               reg_addr,
    input logic [7:0]         reg_wdata,
    input logic               int_req,
    input logic               int_ack,
    input logic               vec_valid,
    input logic [7:0]         vec_num,
    input logic [N_LINES-1:0] isr,
    input logic [N_LINES-1:0] mask_q
);
    localparam int VEC_TOP = VEC_BASE + N_LINES;

    AST_REQ_ONLY_IDLE_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> (isr == '0)); // R7
    AST_ISR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(isr)); // R7
    AST_VEC_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(int_ack) && $past(int_req)); // R6
    AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (int'(vec_num) >= VEC_BASE) && (int'(vec_num) < VEC_TOP)); // R6
    AST_EOI_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_addr && reg_wdata == 8'h20 && isr != '0) |=> (isr == '0)); // R8
    AST_BAD_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_addr && reg_wdata != 8'h20 && isr != '0) |=> $stable(isr)); // R9
    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr) |=> (mask_q == $past(reg_wdata[N_LINES-1:0]))); // R2
    AST_NO_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && !int_req) |=> !vec_valid); // R10
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_LINES(N_LINES), .VEC_BASE(VEC_BASE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .int_req   (int_req),
    .int_ack   (int_ack),
    .vec_valid (vec_valid),
    .vec_num   (vec_num),
    .isr       (isr),
    .mask_q    (mask_q)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/100ps
module prio_irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       int_req;
    logic       int_ack = 1'b0;
    logic       vec_valid;
    logic [7:0] vec_num;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .int_req(int_req), .int_ack(int_ack),
        .vec_valid(vec_valid), .vec_num(vec_num)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wr(logic a, logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cyc(1);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic pulse(logic [7:0] bits);
        irq_in = bits;
        cyc(1);
        irq_in = '0;
    endtask

    task automatic ack(output int vv, output int vn);
        int_ack = 1'b1;
        cyc(1);
        int_ack = 1'b0;
        vv = int'(vec_valid);
        vn = int'(vec_num);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int v, vv, vn;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        check("R1 int_req", int'(int_req), 0);
        rd(1, v); check("R1 mask", v, 8'hFF);
        rd(0, v); check("R1 isr", v, 0);
        cyc(3); check("R1 idle", int'(int_req), 0);

        // R3 blocked line keeps its pending bit
        pulse(8'h01); cyc(3);
        check("R3 blocked", int'(int_req), 0);
        wr(1, 8'h00); rd(1, v); check("R2 mask rd", v, 0);
        cyc(3); check("R3 released", int'(int_req), 1);
        ack(vv, vn); check("R6 vv", vv, 1); check("R6 vec0", vn, 8);
        wr(0, 8'h20);

        // Single-line sweep
        for (int n = 0; n < 8; n++) begin
            pulse(8'(1 << n)); cyc(3);
            check("R4 req", int'(int_req), 1);
            ack(vv, vn);
            check("R6 valid", vv, 1);
            check("R6 vector", vn, 8 + n);
            cyc(1); check("R6 one cycle", int'(vec_valid), 0);
            rd(0, v); check("R7 isr", v, 1 << n);
            pulse(8'hFF); cyc(3);
            check("R7 gated", int'(int_req), 0);
            wr(0, 8'h21); rd(0, v); check("R9 ignored", v, 1 << n);
            wr(0, 8'h00); rd(0, v); check("R9 ignored zero", v, 1 << n);
            wr(0, 8'h20); rd(0, v); check("R8 cleared", v, 0);
            // drain lines raised while in service
            for (int k = 0; k < 8; k++) begin
                cyc(3); check("R8 rerequest", int'(int_req), 1);
                ack(vv, vn); check("R5 drain", vn, 8 + k);
                wr(0, 8'h20);
            end
        end

        // Pair priority sweep
        for (int a = 0; a < 8; a++) begin
            for (int b = a + 1; b < 8; b++) begin
                pulse(8'((1 << a) | (1 << b))); cyc(3);
                ack(vv, vn); check("R5 winner", vn, 8 + a);
                cyc(3); check("R7 loser held", int'(int_req), 0);
                wr(0, 8'h20); cyc(3);
                check("R8 loser req", int'(int_req), 1);
                ack(vv, vn); check("R5 loser", vn, 8 + b);
                wr(0, 8'h20);
            end
        end

        // Mask sweep: block one line while all fire
        for (int n = 0; n < 8; n++) begin
            wr(1, 8'(1 << n)); rd(1, v); check("R2 mask", v, 1 << n);
            pulse(8'hFF);
            for (int k = 0; k < 8; k++) begin
                if (k != n) begin
                    cyc(3); ack(vv, vn); check("R3 order", vn, 8 + k);
                    wr(0, 8'h20);
                end
            end
            cyc(3); check("R3 held masked", int'(int_req), 0);
            wr(1, 8'h00); cyc(3);
            ack(vv, vn); check("R3 late", vn, 8 + n);
            wr(0, 8'h20);
        end

        // R4 held level does not request again
        irq_in = 8'h04; cyc(3);
        ack(vv, vn); check("R4 level first", vn, 10);
        wr(0, 8'h20); cyc(4);
        check("R4 no retrigger", int'(int_req), 0);
        irq_in = '0; cyc(2);

        // R10 acknowledge without a candidate
        ack(vv, vn); check("R10 idle ack", vv, 0);
        rd(0, v); check("R10 idle isr", v, 0);
        pulse(8'h02); cyc(3);
        check("R10 armed", int'(int_req), 1);
        wr(1, 8'h02);
        ack(vv, vn); check("R10 withdrawn", vv, 0);
        rd(0, v); check("R10 isr", v, 0);
        check("R10 req low", int'(int_req), 0);
        wr(1, 8'h00); cyc(3);
        ack(vv, vn); check("R10 later", vn, 9);
        wr(0, 8'h20); cyc(3);
        check("R8 quiet", int'(int_req), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule